// File: doc/BRIEF.md
# Receive Lane Order Restorer

This block sits behind a receive byte deserializer whose parallel word may start halfway through a transmitted word. The transmitted stream carries a known ordering pattern in its lower lane(s). The restorer watches the incoming words while it is armed. When it sees the pattern in the upper lane(s), it inserts pad lane(s) once below the pattern. From then on the pattern, and all data after it, leave the block in the lower lane(s).

The layout is fixed at compile time. Lanes are 8 or 10 bits wide, and the word holds two or four lanes. In the two-lane layout the pattern and the correction are each one lane. In the four-lane layout they are each two lanes. The pattern and the pad lane value are run-time inputs. They are used only while the search is armed. Once ordering is done, the block keeps its shift until a re-arm strobe or reset. Re-arm returns the block to pass-through and starts a new search.

Top module: `lane_order_restorer`

## Requirements
- R1: While reset is high and on the first cycle after it, `dout_vld` and `order_done` are 0 and `dout` is all zeros.
- R2: `dout_vld` equals `din_vld` delayed by exactly one clock cycle.
- R3: While armed, a valid word whose lower and upper halves both differ from `order_pat` is passed to `dout` unchanged on the next cycle, and `order_done` stays 0.
- R4: While armed, a valid word whose lower half equals `order_pat` is passed through unchanged. `order_done` is 1 from the next cycle. Later words also pass through unchanged.
- R5: While armed, a valid word whose upper half equals `order_pat` and whose lower half does not produces {pattern, pad} on `dout`. The pad is `pad_lane` repeated in every lower lane. `order_done` is 1 in the same cycle.
- R6: After an insertion, each valid word W yields {W lower half, upper half of the previous valid word} on `dout`.
- R7: If both halves of a valid armed word equal `order_pat`, the lower-half match wins and no pad is inserted.
- R8: While `order_done` is 1, no new search takes place. A pattern in either half, and any change of `order_pat` or `pad_lane`, leave the output mapping unchanged.
- R9: A cycle with `din_vld` low changes neither `dout` nor the held upper half.
- R10: A `rearm` pulse clears `order_done` on the next cycle and returns the block to pass-through. The next valid word is searched again.
- R11: In the two-lane layout with 10-bit lanes, the pattern is one lane. A match in the upper lane gives {pattern, pad_lane}, and the following word W gives {W lane 0, previous lane 1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | NUM_LANES*LANE_W | Deserialized word, lane 0 in the low bits |
| din_vld | input | 1 | `din` carries a word this cycle |
| order_pat | input | NUM_LANES/2*LANE_W | Ordering pattern expected in the lower lanes |
| pad_lane | input | LANE_W | Value of each inserted pad lane |
| rearm | input | 1 | Clears ordering-done and restarts the search |
| dout | output | NUM_LANES*LANE_W | Reordered word |
| dout_vld | output | 1 | `dout` was updated by a valid word |
| order_done | output | 1 | Ordering pattern has been found |

## Verification
The bench targets the cases where the pattern shows up in both halves at once. A design that favoured the upper match there would insert pad into an already aligned stream. It also sends idle cycles between shifted words. If the held half advanced on those cycles, a lane would be lost and the wrong data would be stitched in. Changes to the pattern and pad after ordering is done are checked as well. A block that kept searching would insert pad a second time mid-stream. Re-arm is checked too, because a block that kept its shift after re-arm would scramble the next aligned stream. A second instance with two 10-bit lanes catches half-width slicing that only suits the four-lane layout.

// File: rtl/lane_order_pkg.sv
package lane_order_pkg;

   // How the output word is assembled on a valid cycle
   typedef enum logic [1:0] {
      MAP_PASS   = 2'd0,   // word as received
      MAP_INSERT = 2'd1,   // {upper half, pad}
      MAP_SHIFT  = 2'd2    // {lower half, held upper half}
   } lane_map_e;

endpackage

// File: rtl/lane_order_detect.sv
module lane_order_detect #(
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 4
) (
   input  logic                                 armed,
   input  logic [NUM_LANES*LANE_W-1:0]          din,
   input  logic [(NUM_LANES/2)*LANE_W-1:0]      order_pat,
   output logic                                 hit_lo,
   output logic                                 hit_hi
);
   localparam int PAT_LANES = NUM_LANES / 2;

   logic [PAT_LANES-1:0] eq_lo;
   logic [PAT_LANES-1:0] eq_hi;

   // per-lane compare of both halves against the pattern
   for (genvar g = 0; g < PAT_LANES; g++) begin : g_cmp
      assign eq_lo[g] = din[g*LANE_W +: LANE_W] == order_pat[g*LANE_W +: LANE_W];
      assign eq_hi[g] = din[(g+PAT_LANES)*LANE_W +: LANE_W] == order_pat[g*LANE_W +: LANE_W];
   end

   assign hit_lo = armed && (&eq_lo);
   assign hit_hi = armed && (&eq_hi);

endmodule

// File: rtl/lane_order_ctrl.sv
module lane_order_ctrl
   import lane_order_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      din_vld,
   input  logic      rearm,
   input  logic      hit_lo,
   input  logic      hit_hi,
   output logic      done,
   output lane_map_e map_sel
);
   logic done_q;
   logic shifted_q;

   always_comb begin
      if (!done_q)
         map_sel = (hit_hi && !hit_lo) ? MAP_INSERT : MAP_PASS;
      else
         map_sel = shifted_q ? MAP_SHIFT : MAP_PASS;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q    <= 1'b0;
         shifted_q <= 1'b0;
      end else if (rearm) begin
         done_q    <= 1'b0;
         shifted_q <= 1'b0;
      end else if (din_vld && !done_q) begin
         if (hit_lo) begin
            done_q <= 1'b1;
         end else if (hit_hi) begin
            done_q    <= 1'b1;
            shifted_q <= 1'b1;
         end
      end
   end

   assign done = done_q;

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (done_q && !rearm) |=> done_q);

   // R10
   rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
      rearm |=> (!done_q && !shifted_q));

   // R4
   done_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
      (!done_q && !din_vld) |=> !done_q);

endmodule

// File: rtl/lane_order_merge.sv
module lane_order_merge
   import lane_order_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [NUM_LANES*LANE_W-1:0]   din,
   input  logic                          din_vld,
   input  lane_map_e                     map_sel,
   input  logic [LANE_W-1:0]             pad_lane,
   output logic [NUM_LANES*LANE_W-1:0]   dout,
   output logic                          dout_vld
);
   localparam int WORD_W = NUM_LANES * LANE_W;
   localparam int HALF_W = WORD_W / 2;

   logic [HALF_W-1:0] pad_fill;
   logic [HALF_W-1:0] hold_q;
   logic [HALF_W-1:0] in_lo;
   logic [HALF_W-1:0] in_hi;

   for (genvar g = 0; g < NUM_LANES / 2; g++) begin : g_pad
      assign pad_fill[g*LANE_W +: LANE_W] = pad_lane;
   end

   assign in_lo = din[HALF_W-1:0];
   assign in_hi = din[WORD_W-1:HALF_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         dout     <= '0;
         dout_vld <= 1'b0;
         hold_q   <= '0;
      end else begin
         dout_vld <= din_vld;
         if (din_vld) begin
            hold_q <= in_hi;
            unique case (map_sel)
               MAP_INSERT: dout <= {in_hi, pad_fill};
               MAP_SHIFT:  dout <= {in_lo, hold_q};
               default:    dout <= din;
            endcase
         end
      end
   end

   // R2
   vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
      din_vld |=> dout_vld);

   // R2
   vld_fall_chk: assert property (@(posedge clk) disable iff (rst)
      !din_vld |=> !dout_vld);

   // R9
   idle_out_chk: assert property (@(posedge clk) disable iff (rst)
      !din_vld |=> $stable(dout));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !din_vld |=> $stable(hold_q));

endmodule

// File: rtl/lane_order_restorer.sv
module lane_order_restorer
   import lane_order_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 4
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic [NUM_LANES*LANE_W-1:0]          din,
   input  logic                                 din_vld,
   input  logic [(NUM_LANES/2)*LANE_W-1:0]      order_pat,
   input  logic [LANE_W-1:0]                    pad_lane,
   input  logic                                 rearm,
   output logic [NUM_LANES*LANE_W-1:0]          dout,
   output logic                                 dout_vld,
   output logic                                 order_done
);
   // elaboration-time parameter checks
   if (!(LANE_W == 8 || LANE_W == 10)) begin : g_bad_lane_w
      $error("lane_order_restorer: LANE_W must be 8 or 10");
   end
   if (!(NUM_LANES == 2 || NUM_LANES == 4)) begin : g_bad_lanes
      $error("lane_order_restorer: NUM_LANES must be 2 or 4");
   end

   logic      hit_lo;
   logic      hit_hi;
   logic      done;
   lane_map_e map_sel;

   lane_order_detect #(
      .LANE_W   (LANE_W),
      .NUM_LANES(NUM_LANES)
   ) u_detect (
      .armed    (!done),
      .din      (din),
      .order_pat(order_pat),
      .hit_lo   (hit_lo),
      .hit_hi   (hit_hi)
   );

   lane_order_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .din_vld(din_vld),
      .rearm  (rearm),
      .hit_lo (hit_lo),
      .hit_hi (hit_hi),
      .done   (done),
      .map_sel(map_sel)
   );

   lane_order_merge #(
      .LANE_W   (LANE_W),
      .NUM_LANES(NUM_LANES)
   ) u_merge (
      .clk     (clk),
      .rst     (rst),
      .din     (din),
      .din_vld (din_vld),
      .map_sel (map_sel),
      .pad_lane(pad_lane),
      .dout    (dout),
      .dout_vld(dout_vld)
   );

   assign order_done = done;

   // R3
   no_match_stay_chk: assert property (@(posedge clk) disable iff (rst)
      (!done && din_vld && !rearm && !hit_lo && !hit_hi) |=> !order_done);

endmodule

// File: tb/tb_lane_order_restorer.sv
`timescale 1ns/1ps
module tb_lane_order_restorer;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   // instance A: four 8-bit lanes
   logic [31:0] a_din = '0;
   logic        a_vld = 1'b0;
   logic [15:0] a_pat = 16'hBC3C;
   logic [7:0]  a_pad = 8'hF7;
   logic        a_rearm = 1'b0;
   logic [31:0] a_dout;
   logic        a_dvld;
   logic        a_done;

   // instance B: two 10-bit lanes
   logic [19:0] b_din = '0;
   logic        b_vld = 1'b0;
   logic [9:0]  b_pat = 10'h17C;
   logic [9:0]  b_pad = 10'h2AA;
   logic        b_rearm = 1'b0;
   logic [19:0] b_dout;
   logic        b_dvld;
   logic        b_done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   lane_order_restorer #(.LANE_W(8), .NUM_LANES(4)) dut (
      .clk(clk), .rst(rst), .din(a_din), .din_vld(a_vld), .order_pat(a_pat),
      .pad_lane(a_pad), .rearm(a_rearm), .dout(a_dout), .dout_vld(a_dvld),
      .order_done(a_done)
   );

   lane_order_restorer #(.LANE_W(10), .NUM_LANES(2)) dut_b (
      .clk(clk), .rst(rst), .din(b_din), .din_vld(b_vld), .order_pat(b_pat),
      .pad_lane(b_pad), .rearm(b_rearm), .dout(b_dout), .dout_vld(b_dvld),
      .order_done(b_done)
   );

   task automatic check(string req, logic [39:0] act, logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push_a(logic [31:0] w, logic v);
      a_din = w;
      a_vld = v;
      @(negedge clk);
      a_vld = 1'b0;
   endtask

   task automatic push_b(logic [19:0] w, logic v);
      b_din = w;
      b_vld = v;
      @(negedge clk);
      b_vld = 1'b0;
   endtask

   task automatic rearm_a();
      a_rearm = 1'b1;
      @(negedge clk);
      a_rearm = 1'b0;
      check("R10 done cleared", {39'd0, a_done}, 40'd0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 dout_vld in reset", {39'd0, a_dvld}, 40'd0);
      check("R1 done in reset", {39'd0, a_done}, 40'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 dout after reset", {8'd0, a_dout}, 40'd0);
      check("R1 done after reset", {39'd0, a_done}, 40'd0);
   endtask

   task automatic t_pass();
      push_a(32'h1111_2222, 1'b1);
      check("R3 pass word", {8'd0, a_dout}, 40'h11112222);
      check("R2 valid follows", {39'd0, a_dvld}, 40'd1);
      check("R3 done stays low", {39'd0, a_done}, 40'd0);
      push_a(32'h5A5A_5A5A, 1'b0);
      check("R2 valid drops", {39'd0, a_dvld}, 40'd0);
      check("R9 dout holds on idle", {8'd0, a_dout}, 40'h11112222);
   endtask

   task automatic t_low_hit();
      push_a(32'hAAAA_BC3C, 1'b1);
      check("R4 aligned word passes", {8'd0, a_dout}, 40'hAAAABC3C);
      check("R4 done set", {39'd0, a_done}, 40'd1);
      push_a(32'h1234_5678, 1'b1);
      check("R4 later word passes", {8'd0, a_dout}, 40'h12345678);
      push_a(32'hBC3C_0000, 1'b1);
      check("R8 upper pattern ignored", {8'd0, a_dout}, 40'hBC3C0000);
      check("R8 done kept", {39'd0, a_done}, 40'd1);
      rearm_a();
   endtask

   task automatic t_insert();
      push_a(32'hBC3C_5555, 1'b1);
      check("R5 pad inserted", {8'd0, a_dout}, 40'hBC3CF7F7);
      check("R5 done set", {39'd0, a_done}, 40'd1);
      push_a(32'h6666_7777, 1'b1);
      check("R6 shifted word", {8'd0, a_dout}, 40'h7777BC3C);
      a_pat = 16'h6666;
      a_pad = 8'h00;
      push_a(32'hDEAD_BEEF, 1'b0);
      check("R9 idle keeps dout", {8'd0, a_dout}, 40'h7777BC3C);
      push_a(32'h8888_9999, 1'b1);
      check("R9 hold not advanced by idle", {8'd0, a_dout}, 40'h99996666);
      push_a(32'h6666_BC3C, 1'b1);
      check("R8 no second insertion", {8'd0, a_dout}, 40'hBC3C8888);
      a_pat = 16'hBC3C;
      a_pad = 8'hF7;
      rearm_a();
      push_a(32'h0102_0304, 1'b1);
      check("R10 pass-through after rearm", {8'd0, a_dout}, 40'h01020304);
      check("R10 search armed again", {39'd0, a_done}, 40'd0);
   endtask

   task automatic t_both();
      push_a(32'hBC3C_BC3C, 1'b1);
      check("R7 low match wins", {8'd0, a_dout}, 40'hBC3CBC3C);
      push_a(32'h4444_3333, 1'b1);
      check("R7 no shift after low match", {8'd0, a_dout}, 40'h44443333);
   endtask

   task automatic t_two_lane();
      push_b({10'h017, 10'h001}, 1'b1);
      check("R11 no match passes", {20'd0, b_dout}, {20'd0, 10'h017, 10'h001});
      push_b({10'h17C, 10'h001}, 1'b1);
      check("R11 single pad lane", {20'd0, b_dout}, {20'd0, 10'h17C, 10'h2AA});
      check("R11 done set", {39'd0, b_done}, 40'd1);
      push_b({10'h003, 10'h002}, 1'b1);
      check("R11 shifted lane", {20'd0, b_dout}, {20'd0, 10'h002, 10'h17C});
      push_b({10'h005, 10'h004}, 1'b1);
      check("R11 stream stays shifted", {20'd0, b_dout}, {20'd0, 10'h004, 10'h003});
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_pass();
      t_low_hit();
      t_insert();
      t_both();
      t_two_lane();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule